// File: doc/BRIEF.md
# CAN Controller Interrupt and Status Unit

This block holds the register-side status and interrupt state of a CAN controller that can present either a basic or an extended register set. Software reaches it through single-cycle read and write strobes carrying a 3-bit address and a byte of data. The rest of the controller signals events to it as one-cycle pulses: reception has begun, a frame has been received (with its length in bytes), transmission has begun, and transmission has finished. From these inputs the unit keeps a status byte, an interrupt-flag byte, a count of received messages that software has not yet released, and the fill level in bytes of a 64-byte receive buffer.

One level-sensitive interrupt line is computed at all times from the stored flags, the enables and the selected mode. It is never pulsed on a single event. A single set of status and flag bits serves both modes. The mode only selects which enable source gates the flags.

Register addresses: 0 control, 1 command (write only), 2 status, 3 interrupt flags (read clears), 4 interrupt enable, 5 clock divider, 6 pending-message count (read only), 7 buffer fill level (read only). Writes to addresses 2, 3, 6 and 7 are ignored.

Top module: `can_irq_status_unit`

## Requirements
- R1: After reset every register, the pending count and the fill level are zero, basic mode is selected, `irq` is low and `rd_data` is zero.
- R2: When bit 7 of the clock-divider register is 1 (extended mode), `irq` is high exactly when the interrupt-enable register ANDed with the flag byte is nonzero.
- R3: When bit 7 of the clock-divider register is 0 (basic mode), control bits 1, 2, 3 and 4 enable flag bits 0, 1, 2 and 3 respectively, and the interrupt-enable register has no effect on `irq`.
- R4: A received frame whose length fits in the buffer adds its length to the fill level, raises the pending count by one, sets flag bit 0 and status bit 0, and clears status bit 4.
- R5: A received frame that would take the fill level above 64 bytes is discarded, leaving the count and the fill level unchanged. It sets status bit 1 and flag bit 3 and clears status bit 4. A frame that brings the fill level to exactly 64 is accepted.
- R6: A reception-begin pulse sets status bit 4. A transmission-begin pulse sets status bit 5. A transmit-done pulse sets flag bit 1 and clears status bit 5.
- R7: A command write with bit 2 set releases one message and lowers the pending count by one. When the count reaches zero, status bit 0 and flag bit 0 clear and the fill level returns to zero. A release while the count is zero changes nothing.
- R8: A command write with bit 3 set clears status bit 1 and flag bit 3.
- R9: A read of address 3 returns the flag byte and then clears every flag. Flag bit 0 is set again at once while messages are still pending.
- R10: `irq` follows every change of flags, enables, control bits or mode in the cycle in which that change is stored.
- R11: A read strobe presents the addressed register on `rd_data` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, registered |
| rx_begin | input | 1 | Reception has started |
| rx_done | input | 1 | A frame was received |
| rx_len | input | LEN_W | Byte length of the received frame |
| tx_begin | input | 1 | Transmission has started |
| tx_done | input | 1 | Transmission finished |
| irq | output | 1 | Level-sensitive interrupt request |

## Verification
Every register write, event pulse and read-clear takes effect at the clock edge on which it is presented. Because `irq` is decoded from the stored state without a further register, it shows the new level right after that same edge. Read data arrives through one output register, so it is due one edge after the strobe. The bench drives each stimulus on a falling edge, lets one rising edge pass, and samples both `irq` and `rd_data` at the next falling edge. In this way every result is observed exactly in the cycle it is due, and never a cycle late.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_CMD   = 3'd1,
        A_STAT  = 3'd2,
        A_IFLAG = 3'd3,
        A_IEN   = 3'd4,
        A_CDIV  = 3'd5,
        A_PEND  = 3'd6,
        A_FILL  = 3'd7
    } reg_addr_e;

    localparam int MODE_BIT    = 7;
    localparam int ST_RXFULL   = 0;
    localparam int ST_OVR      = 1;
    localparam int ST_RXBUSY   = 4;
    localparam int ST_TXBUSY   = 5;
    localparam int IF_RX       = 0;
    localparam int IF_TX       = 1;
    localparam int IF_OVR      = 3;
    localparam int CMD_RELEASE = 2;
    localparam int CMD_CLROVR  = 3;

    typedef struct packed {
        logic accept;
        logic overrun;
        logic last_release;
        logic pend_nz;
    } rx_evt_t;

    typedef struct packed {
        logic rd_iflag;
        logic clr_ovr;
        logic rx_begin;
        logic tx_begin;
        logic tx_done;
    } flag_ctl_t;

    function automatic logic irq_level(input logic ext, input logic [7:0] ien,
                                       input logic [7:0] ctrl, input logic [7:0] iflag);
        if (ext) return |(ien & iflag);
        return |((ctrl >> 1) & iflag);
    endfunction

endpackage

// File: rtl/can_irq_rxtrack.sv
module can_irq_rxtrack
    import can_irq_pkg::*;
#(
    parameter int CAP_BYTES = 64,
    parameter int LEN_W     = 4,
    localparam int FILL_W   = $clog2(CAP_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic              release_req,
    output rx_evt_t           evt,
    output logic [FILL_W-1:0] pend_cnt,
    output logic [FILL_W-1:0] fill
);
    localparam int SUM_W = (FILL_W > LEN_W ? FILL_W : LEN_W) + 1;
    localparam logic [FILL_W-1:0] CNT_MAX = {FILL_W{1'b1}};

    logic [SUM_W-1:0]  sum;
    logic              fits, rel_ok;
    logic [FILL_W-1:0] cnt_nx, fill_nx;

    always_comb begin
        sum    = SUM_W'(fill) + SUM_W'(rx_len);
        fits   = (sum <= SUM_W'(CAP_BYTES)) && (pend_cnt != CNT_MAX);
        rel_ok = release_req && (pend_cnt != '0);
        evt.accept  = rx_valid && fits;
        evt.overrun = rx_valid && !fits;
        cnt_nx = pend_cnt + FILL_W'(evt.accept) - FILL_W'(rel_ok);
        evt.last_release = rel_ok && (cnt_nx == '0);
        evt.pend_nz      = (cnt_nx != '0);
        if (evt.last_release)
            fill_nx = '0;
        else if (evt.accept)
            fill_nx = FILL_W'(sum);
        else
            fill_nx = fill;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_cnt <= '0;
            fill     <= '0;
        end else begin
            pend_cnt <= cnt_nx;
            fill     <= fill_nx;
        end
    end

    p_fill_cap_r5: assert property (@(posedge clk) disable iff (rst)
        fill <= FILL_W'(CAP_BYTES));

    p_overrun_keeps_state_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !fits && !release_req) |=> ($stable(pend_cnt) && $stable(fill)));

    p_idle_release_r7: assert property (@(posedge clk) disable iff (rst)
        (release_req && pend_cnt == '0 && !rx_valid) |=> (pend_cnt == '0 && $stable(fill)));

endmodule

// File: rtl/can_irq_flags.sv
module can_irq_flags
    import can_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  flag_ctl_t  ctl,
    input  rx_evt_t    evt,
    output logic [7:0] status,
    output logic [7:0] iflag
);
    logic [7:0] ns, nf;

    always_comb begin
        ns = status;
        nf = iflag;
        if (ctl.rd_iflag) begin
            nf = '0;
            nf[IF_RX] = evt.pend_nz;
        end
        if (evt.last_release) begin
            ns[ST_RXFULL] = 1'b0;
            nf[IF_RX]     = 1'b0;
        end
        if (ctl.clr_ovr) begin
            ns[ST_OVR] = 1'b0;
            nf[IF_OVR] = 1'b0;
        end
        if (ctl.rx_begin) ns[ST_RXBUSY] = 1'b1;
        if (ctl.tx_begin) ns[ST_TXBUSY] = 1'b1;
        if (evt.accept) begin
            nf[IF_RX]     = 1'b1;
            ns[ST_RXFULL] = 1'b1;
            ns[ST_RXBUSY] = 1'b0;
        end
        if (evt.overrun) begin
            nf[IF_OVR]    = 1'b1;
            ns[ST_OVR]    = 1'b1;
            ns[ST_RXBUSY] = 1'b0;
        end
        if (ctl.tx_done) begin
            nf[IF_TX]     = 1'b1;
            ns[ST_TXBUSY] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            iflag  <= '0;
        end else begin
            status <= ns;
            iflag  <= nf;
        end
    end

    p_accept_sets_r4: assert property (@(posedge clk) disable iff (rst)
        evt.accept |=> (iflag[IF_RX] && status[ST_RXFULL] && !status[ST_RXBUSY]));

    p_txdone_r6: assert property (@(posedge clk) disable iff (rst)
        ctl.tx_done |=> (iflag[IF_TX] && !status[ST_TXBUSY]));

    p_clear_overrun_r8: assert property (@(posedge clk) disable iff (rst)
        (ctl.clr_ovr && !evt.overrun) |=> (!iflag[IF_OVR] && !status[ST_OVR]));

    p_read_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (ctl.rd_iflag && !evt.pend_nz && !evt.accept && !evt.overrun && !ctl.tx_done)
        |=> (iflag == 8'h00));

endmodule

// File: rtl/can_irq_gate.sv
module can_irq_gate
    import can_irq_pkg::*;
(
    input  logic [7:0] cdiv,
    input  logic [7:0] ien,
    input  logic [7:0] ctrl,
    input  logic [7:0] iflag,
    output logic       irq
);
    always_comb irq = irq_level(cdiv[MODE_BIT], ien, ctrl, iflag);
endmodule

// File: rtl/can_irq_status_unit.sv
module can_irq_status_unit
    import can_irq_pkg::*;
#(
    parameter int CAP_BYTES = 64,
    parameter int LEN_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [2:0]       addr,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    input  logic             rx_begin,
    input  logic             rx_done,
    input  logic [LEN_W-1:0] rx_len,
    input  logic             tx_begin,
    input  logic             tx_done,
    output logic             irq
);
    localparam int FILL_W = $clog2(CAP_BYTES + 1);

    reg_addr_e         ra;
    logic [7:0]        ctrl_q, ien_q, cdiv_q, status, iflag;
    logic [FILL_W-1:0] pend_cnt, fill;
    logic              cmd_wr;
    rx_evt_t           evt;
    flag_ctl_t         ctl;

    always_comb begin
        ra     = reg_addr_e'(addr);
        cmd_wr = wr_en && (ra == A_CMD);
        ctl.rd_iflag = rd_en && (ra == A_IFLAG);
        ctl.clr_ovr  = cmd_wr && wr_data[CMD_CLROVR];
        ctl.rx_begin = rx_begin;
        ctl.tx_begin = tx_begin;
        ctl.tx_done  = tx_done;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            ien_q   <= '0;
            cdiv_q  <= '0;
            rd_data <= '0;
        end else begin
            if (wr_en) begin
                case (ra)
                    A_CTRL:  ctrl_q <= wr_data;
                    A_IEN:   ien_q  <= wr_data;
                    A_CDIV:  cdiv_q <= wr_data;
                    default: ;
                endcase
            end
            if (rd_en) begin
                case (ra)
                    A_CTRL:  rd_data <= ctrl_q;
                    A_STAT:  rd_data <= status;
                    A_IFLAG: rd_data <= iflag;
                    A_IEN:   rd_data <= ien_q;
                    A_CDIV:  rd_data <= cdiv_q;
                    A_PEND:  rd_data <= 8'(pend_cnt);
                    A_FILL:  rd_data <= 8'(fill);
                    default: rd_data <= '0;
                endcase
            end
        end
    end

    can_irq_rxtrack #(.CAP_BYTES(CAP_BYTES), .LEN_W(LEN_W)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .rx_valid    (rx_done),
        .rx_len      (rx_len),
        .release_req (cmd_wr && wr_data[CMD_RELEASE]),
        .evt         (evt),
        .pend_cnt    (pend_cnt),
        .fill        (fill)
    );

    can_irq_flags u_flags (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .evt    (evt),
        .status (status),
        .iflag  (iflag)
    );

    can_irq_gate u_gate (
        .cdiv  (cdiv_q),
        .ien   (ien_q),
        .ctrl  (ctrl_q),
        .iflag (iflag),
        .irq   (irq)
    );

    p_pending_needs_rxflag_r7: assert property (@(posedge clk) disable iff (rst)
        (evt.last_release && !evt.accept) |=> (!status[ST_RXFULL] && fill == '0));

endmodule

// File: tb/sim_can_irq_status_unit.sv
module sim_can_irq_status_unit;
    localparam int LEN_W = 4;

    logic clk = 1'b0;
    logic rst, wr_en, rd_en, rx_begin, rx_done, tx_begin, tx_done, irq;
    logic [2:0] addr;
    logic [7:0] wr_data, rd_data;
    logic [LEN_W-1:0] rx_len;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    can_irq_status_unit #(.CAP_BYTES(64), .LEN_W(LEN_W)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .rx_begin(rx_begin),
        .rx_done(rx_done), .rx_len(rx_len), .tx_begin(tx_begin),
        .tx_done(tx_done), .irq(irq)
    );

    // entry: op[26:24] addr[23:21] data[20:13] exp[12:5] irq[4] req[3:0]
    // op: 0 write, 1 read, 2 frame received (data = length), 3 tx done, 4 rx begin, 5 tx begin
    localparam int NV = 52;
    localparam logic [26:0] VEC [NV] = '{
        {3'd1,3'd0,8'h00,8'h00,1'b0,4'd1},  // R1 control zero
        {3'd1,3'd2,8'h00,8'h00,1'b0,4'd1},  // R1 status zero
        {3'd1,3'd3,8'h00,8'h00,1'b0,4'd1},  // R1 flags zero
        {3'd1,3'd5,8'h00,8'h00,1'b0,4'd1},  // R1 basic mode
        {3'd0,3'd0,8'h02,8'h00,1'b0,4'd3},  // R3 enable receive flag
        {3'd4,3'd0,8'h00,8'h00,1'b0,4'd6},  // R6 rx begin
        {3'd1,3'd2,8'h00,8'h10,1'b0,4'd6},  // R6 status bit4
        {3'd2,3'd0,8'h0A,8'h00,1'b1,4'd4},  // R4 frame len 10
        {3'd1,3'd2,8'h00,8'h01,1'b1,4'd4},  // R4 status
        {3'd1,3'd6,8'h00,8'h01,1'b1,4'd4},  // R4 count
        {3'd1,3'd7,8'h00,8'h0A,1'b1,4'd4},  // R4 fill
        {3'd0,3'd4,8'hFF,8'h00,1'b1,4'd3},  // R3 enables written
        {3'd0,3'd0,8'h00,8'h00,1'b0,4'd3},  // R3 enable register ignored in basic
        {3'd0,3'd5,8'h80,8'h00,1'b1,4'd10}, // R10 mode switch
        {3'd0,3'd4,8'h02,8'h00,1'b0,4'd2},  // R2 mask receive
        {3'd3,3'd0,8'h00,8'h00,1'b1,4'd6},  // R6 tx done
        {3'd1,3'd2,8'h00,8'h01,1'b1,4'd6},
        {3'd1,3'd3,8'h00,8'h03,1'b0,4'd9},  // R9 read clears
        {3'd1,3'd3,8'h00,8'h01,1'b0,4'd9},  // R9 receive flag back
        {3'd2,3'd0,8'h0F,8'h00,1'b0,4'd4},
        {3'd2,3'd0,8'h0F,8'h00,1'b0,4'd4},
        {3'd2,3'd0,8'h0F,8'h00,1'b0,4'd4},
        {3'd2,3'd0,8'h0A,8'h00,1'b0,4'd5},  // R5 overrun 65 > 64
        {3'd1,3'd7,8'h00,8'h37,1'b0,4'd5},
        {3'd1,3'd6,8'h00,8'h04,1'b0,4'd5},
        {3'd1,3'd2,8'h00,8'h03,1'b0,4'd5},
        {3'd0,3'd4,8'h08,8'h00,1'b1,4'd2},  // R2 overrun enable
        {3'd1,3'd3,8'h00,8'h09,1'b0,4'd9},
        {3'd2,3'd0,8'h0A,8'h00,1'b1,4'd5},  // R5 overrun again
        {3'd0,3'd1,8'h08,8'h00,1'b0,4'd8},  // R8 clear overrun
        {3'd1,3'd2,8'h00,8'h01,1'b0,4'd8},
        {3'd2,3'd0,8'h09,8'h00,1'b0,4'd5},  // R5 exact fit to 64
        {3'd1,3'd7,8'h00,8'h40,1'b0,4'd5},
        {3'd0,3'd4,8'h01,8'h00,1'b1,4'd2},
        {3'd0,3'd1,8'h04,8'h00,1'b1,4'd7},  // R7 release
        {3'd0,3'd1,8'h04,8'h00,1'b1,4'd7},
        {3'd0,3'd1,8'h04,8'h00,1'b1,4'd7},
        {3'd0,3'd1,8'h04,8'h00,1'b1,4'd7},
        {3'd0,3'd1,8'h04,8'h00,1'b0,4'd7},  // R7 last release
        {3'd1,3'd6,8'h00,8'h00,1'b0,4'd7},
        {3'd1,3'd7,8'h00,8'h00,1'b0,4'd7},
        {3'd1,3'd2,8'h00,8'h00,1'b0,4'd7},
        {3'd0,3'd1,8'h04,8'h00,1'b0,4'd7},  // R7 release at zero
        {3'd1,3'd6,8'h00,8'h00,1'b0,4'd7},
        {3'd0,3'd5,8'h00,8'h00,1'b0,4'd10},
        {3'd0,3'd0,8'h04,8'h00,1'b0,4'd3},
        {3'd5,3'd0,8'h00,8'h00,1'b0,4'd6},  // R6 tx begin
        {3'd1,3'd2,8'h00,8'h20,1'b0,4'd6},
        {3'd3,3'd0,8'h00,8'h00,1'b1,4'd6},
        {3'd1,3'd2,8'h00,8'h00,1'b1,4'd6},
        {3'd1,3'd3,8'h00,8'h02,1'b0,4'd9},
        {3'd1,3'd3,8'h00,8'h00,1'b0,4'd9}
    };

    task automatic idle();
        wr_en = 0; rd_en = 0; rx_begin = 0; rx_done = 0; tx_begin = 0; tx_done = 0;
    endtask

    task automatic chk(input string what, input int req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [26:0] v);
        @(negedge clk);
        addr = v[23:21];
        wr_data = v[20:13];
        rx_len = v[16:13];
        case (v[26:24])
            3'd0: wr_en = 1;
            3'd1: rd_en = 1;
            3'd2: rx_done = 1;
            3'd3: tx_done = 1;
            3'd4: rx_begin = 1;
            default: tx_begin = 1;
        endcase
        @(negedge clk);
        idle();
        if (v[26:24] == 3'd1) chk("rd_data", int'(v[3:0]), rd_data, v[12:5]);
        chk("irq", int'(v[3:0]), {7'd0, irq}, {7'd0, v[4]});
    endtask

    initial begin
        rst = 1; addr = 0; wr_data = 0; rx_len = 0; idle();
        repeat (3) @(negedge clk);
        rst = 0;
        chk("irq after reset R1", 1, {7'd0, irq}, 8'h00);
        chk("rd_data after reset R1", 1, rd_data, 8'h00);
        for (int i = 0; i < NV; i++) step(VEC[i]);

        // R1: reset from a busy state returns everything to zero
        step({3'd0,3'd0,8'h02,8'h00,1'b0,4'd1});
        step({3'd2,3'd0,8'h05,8'h00,1'b1,4'd4});
        @(negedge clk); rst = 1; @(negedge clk); rst = 0;
        chk("irq after mid reset R1", 1, {7'd0, irq}, 8'h00);
        step({3'd1,3'd6,8'h00,8'h00,1'b0,4'd1});
        step({3'd1,3'd0,8'h00,8'h00,1'b0,4'd1});
        // R9: basic mode, read-clear with a message pending keeps irq high
        step({3'd0,3'd0,8'h02,8'h00,1'b0,4'd9});
        step({3'd2,3'd0,8'h05,8'h00,1'b1,4'd9});
        step({3'd1,3'd3,8'h00,8'h01,1'b1,4'd9});
        // R3: overrun gated by control bit 4 in basic mode
        step({3'd0,3'd0,8'h10,8'h00,1'b0,4'd3});
        step({3'd0,3'd2,8'hFF,8'h00,1'b0,4'd3}); // write to status ignored
        step({3'd1,3'd2,8'h00,8'h01,1'b0,4'd3});
        // R11: read of control returns the written value one clock later
        step({3'd1,3'd0,8'h00,8'h10,1'b0,4'd11});

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule